// File: doc/BRIEF.md
# Paced FSK Packet Framer

This block assembles a fixed-layout radio packet and presents it one bit at a time on a single FSK data line. The radio paces the transfer. It pulls an active-low bit-request line low and then releases it, and each release moves the next bit onto the line. The request line is asynchronous, so the block passes it through a synchronizer before it looks for the rising edge.

Each packet is framed in the same way. It opens with a preamble and a two-byte sync pattern. Next come sixteen payload bytes from an internal register file, an additive checksum and a short trailer. Before the first bit, the block asks for a transmitter-on command word through a request/acknowledge port. After the last bit, it asks for a transmitter-off word through the same port. Software-style loading of the first thirteen payload bytes goes through a small write port, which only accepts writes while the block is idle.

The last three payload bytes are not written by the host. They always hold the ASCII decimal digits of an internal packet counter, which advances once per finished packet. After a packet ends, the block waits for a programmable gap before it starts the next one. A start pulse can cut the gap short.

Top module: `fsk_packet_framer`

## Requirements
- R1: A packet is 24 bytes. Bytes 0 to 2 are 0xAA, byte 3 is 0x2D and byte 4 is 0xD4. Bytes 5 to 20 are the payload, byte 21 is the checksum, and bytes 22 and 23 are 0xAA.
- R2: Payload byte k (k = 0..15) is packet byte 5+k. Payload bytes 0 to 12 are the values last written to addresses 0 to 12, and they are zero after reset.
- R3: The checksum byte is the sum of the 16 payload bytes modulo 256. Preamble and sync bytes are not part of the sum.
- R4: Each byte leaves on `fsk_out` most significant bit first.
- R5: A low-to-high change of `bit_req_n` that is first captured at clock edge n moves the next packet bit onto `fsk_out` at edge n+2. Nothing else changes `fsk_out` while a packet is running.
- R6: A packet starts with `cmd_valid` high and `cmd_word` equal to ON_WORD. The word stays steady until `cmd_ack`, and no bit is sent before that acknowledge. After the 192nd bit, `cmd_valid` rises with OFF_WORD and stays steady until `cmd_ack`.
- R7: After reset, `fsk_out` is 1 and both `busy` and `cmd_valid` are 0. The acknowledge that ends a packet also returns `fsk_out` to 1.
- R8: An 8-bit packet counter starts at 0. It increments on each acknowledged off command and wraps from 255 to 0. Payload bytes 13, 14 and 15 are 0x30 plus the hundreds, tens and units digits of the counter.
- R9: `busy` is high from the cycle after idle is left until the off command is acknowledged. Without `start`, the idle gap lasts exactly GAP_CYCLES clocks.
- R10: A `start` pulse while idle launches the on command at the next clock. A `start` pulse while busy has no effect.
- R11: A write (`wr_en` with `wr_addr`, `wr_data`) changes payload bytes only while idle and only when the address is 0 to 12. Writes at other addresses, or writes made while busy, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_req_n | input | 1 | Asynchronous active-low bit request from the radio |
| start | input | 1 | Launch a packet now when idle |
| wr_en | input | 1 | Payload write strobe |
| wr_addr | input | 4 | Payload byte address (0 to 12 writable) |
| wr_data | input | 8 | Payload byte value |
| cmd_valid | output | 1 | Command word request |
| cmd_word | output | 16 | Transmitter on/off command word |
| cmd_ack | input | 1 | Command accepted |
| fsk_out | output | 1 | Serial FSK data bit |
| busy | output | 1 | Packet in progress |

## Verification
A wrong byte index or bit index in this block corrupts `fsk_out` within a few request edges, and a wrong payload register shows up when its byte is sent. A checksum that drifts is seen only at byte 21, and a stale counter is seen only when bytes 18 to 20 of the next packet are sent. For that reason, the reference model runs many packets back to back, all the way through the counter wrap. A state that leaves idle early or late shows up at once on `busy` and `cmd_valid`. The model checks these outputs every cycle.

// File: rtl/fsk_packet_framer.sv
module fsk_packet_framer #(
  parameter int          GAP_CYCLES = 1000,
  parameter logic [15:0] ON_WORD    = 16'h8E31,
  parameter logic [15:0] OFF_WORD   = 16'h8E01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_req_n,
  input  logic        start,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic        cmd_valid,
  output logic [15:0] cmd_word,
  input  logic        cmd_ack,
  output logic        fsk_out,
  output logic        busy
);
  localparam int PRE_BYTES  = 3;
  localparam int PAY_FIRST  = PRE_BYTES + 2;
  localparam int USER_BYTES = 13;
  localparam int PAY_BYTES  = 16;
  localparam int CHK_BYTE   = PAY_FIRST + PAY_BYTES;
  localparam int LAST_BYTE  = CHK_BYTE + 2;
  localparam int GW         = $clog2(GAP_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_ON, S_SEND, S_OFF} st_t;

  st_t                      st;
  logic [2:0]               req_q;
  logic [GW-1:0]            gap_cnt;
  logic [4:0]               byte_idx;
  logic [2:0]               bit_idx;
  logic [USER_BYTES-1:0][7:0] pay;
  logic [7:0]               chk;
  logic [7:0]               pkt_cnt;
  logic                     fsk_q;
  logic [7:0]               cur_byte;
  logic [3:0]               pay_sel;

  wire bit_edge = req_q[1] & ~req_q[2];
  wire [7:0] dig_h = 8'h30 + pkt_cnt / 8'd100;
  wire [7:0] dig_t = 8'h30 + (pkt_cnt / 8'd10) % 8'd10;
  wire [7:0] dig_u = 8'h30 + pkt_cnt % 8'd10;
  wire in_pay = (byte_idx >= 5'(PAY_FIRST)) && (byte_idx < 5'(CHK_BYTE));

  assign pay_sel   = 4'(byte_idx - 5'(PAY_FIRST));
  assign busy      = (st != S_IDLE);
  assign cmd_valid = (st == S_ON) || (st == S_OFF);
  assign cmd_word  = (st == S_OFF) ? OFF_WORD : ON_WORD;
  assign fsk_out   = fsk_q;

  always_comb begin
    if (byte_idx < 5'(PRE_BYTES))                cur_byte = 8'hAA;
    else if (byte_idx == 5'(PRE_BYTES))          cur_byte = 8'h2D;
    else if (byte_idx == 5'(PRE_BYTES + 1))      cur_byte = 8'hD4;
    else if (byte_idx < 5'(PAY_FIRST + USER_BYTES)) cur_byte = pay[pay_sel];
    else if (byte_idx == 5'(PAY_FIRST + 13))     cur_byte = dig_h;
    else if (byte_idx == 5'(PAY_FIRST + 14))     cur_byte = dig_t;
    else if (byte_idx == 5'(PAY_FIRST + 15))     cur_byte = dig_u;
    else if (byte_idx == 5'(CHK_BYTE))           cur_byte = chk;
    else                                          cur_byte = 8'hAA;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 3'b111;
    else        req_q <= {req_q[1:0], bit_req_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      gap_cnt  <= '0;
      byte_idx <= '0;
      bit_idx  <= '0;
      pay      <= '0;
      chk      <= '0;
      pkt_cnt  <= '0;
      fsk_q    <= 1'b1;
    end else begin
      case (st)
        S_IDLE: begin
          chk      <= '0;
          byte_idx <= '0;
          bit_idx  <= '0;
          if (wr_en && wr_addr < 4'(USER_BYTES)) pay[wr_addr] <= wr_data;
          if (start || gap_cnt == GW'(GAP_CYCLES - 1)) begin
            st      <= S_ON;
            gap_cnt <= '0;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_ON: if (cmd_ack) st <= S_SEND;
        S_SEND: if (bit_edge) begin
          fsk_q   <= cur_byte[3'd7 - bit_idx];
          bit_idx <= bit_idx + 3'd1;
          if (bit_idx == 3'd7) begin
            if (in_pay) chk <= chk + cur_byte;
            if (byte_idx == 5'(LAST_BYTE)) st <= S_OFF;
            else byte_idx <= byte_idx + 5'd1;
          end
        end
        S_OFF: if (cmd_ack) begin
          st      <= S_IDLE;
          pkt_cnt <= pkt_cnt + 8'd1;
          fsk_q   <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_word)); // R6
  AST_FSK_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    !(st == S_SEND && bit_edge) && !(st == S_OFF && cmd_ack) |=> $stable(fsk_out)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_OFF && cmd_ack |=> pkt_cnt == $past(pkt_cnt) + 8'd1); // R8
  AST_PAY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pay)); // R11
  AST_GAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= GW'(GAP_CYCLES - 1)); // R9
  AST_START_GO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && cmd_valid && cmd_word == ON_WORD); // R10
endmodule

// File: tb/fsk_packet_framer_bench.sv
`timescale 1ns/1ps
module fsk_packet_framer_bench;
  localparam int          GAP = 40;
  localparam logic [15:0] ONW = 16'h8E31;
  localparam logic [15:0] OFW = 16'h8E01;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bit_req_n, start, wr_en, cmd_ack;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic cmd_valid, fsk_out, busy;
  logic [15:0] cmd_word;

  fsk_packet_framer #(.GAP_CYCLES(GAP), .ON_WORD(ONW), .OFF_WORD(OFW)) u_fsk_packet_framer (
    .clk(clk), .rst_n(rst_n), .bit_req_n(bit_req_n), .start(start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ack(cmd_ack),
    .fsk_out(fsk_out), .busy(busy));

  int errors = 0, checks = 0;
  int m_mode, m_gap, m_bit, m_cnt, pkts_done;
  logic [7:0] m_pay [13];
  logic [7:0] m_pkt [24];
  logic m_fsk;
  logic [3:0] hist;
  bit fast = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic void build_packet();
    int sum = 0;
    for (int i = 0; i < 3; i++) m_pkt[i] = 8'hAA;
    m_pkt[3] = 8'h2D; m_pkt[4] = 8'hD4;
    for (int i = 0; i < 13; i++) m_pkt[5+i] = m_pay[i];
    m_pkt[18] = 8'(48 + m_cnt / 100);
    m_pkt[19] = 8'(48 + (m_cnt / 10) % 10);
    m_pkt[20] = 8'(48 + m_cnt % 10);
    for (int i = 5; i < 21; i++) sum += m_pkt[i];
    m_pkt[21] = 8'(sum % 256);
    m_pkt[22] = 8'hAA; m_pkt[23] = 8'hAA;
  endfunction

  function automatic string fsk_tag();
    int b;
    if (m_bit == 0) return "R7 fsk_out";
    b = (m_bit - 1) / 8;
    if (b < 5 || b > 21) return "R1 R4 R5 fsk_out framing";
    if (b < 18) return "R2 R11 R4 R5 fsk_out payload";
    if (b < 21) return "R8 R11 R4 R5 fsk_out counter digits";
    return "R3 R4 R5 fsk_out checksum";
  endfunction

  // reference model, advanced on each clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_gap = 0; m_bit = 0; m_cnt = 0; m_fsk = 1'b1; hist = 4'hF;
      for (int i = 0; i < 13; i++) m_pay[i] = 8'h00;
    end else begin
      bit e;
      e = hist[1] & ~hist[2];
      hist = {hist[2:0], bit_req_n};
      case (m_mode)
        0: begin
          if (wr_en && wr_addr < 13) m_pay[wr_addr] = wr_data;
          if (start || m_gap == GAP - 1) begin m_mode = 1; m_gap = 0; end
          else m_gap++;
        end
        1: if (cmd_ack) begin build_packet(); m_bit = 0; m_mode = 2; end
        2: if (e) begin
          m_fsk = m_pkt[m_bit / 8][7 - m_bit % 8];
          m_bit++;
          if (m_bit == 192) m_mode = 3;
        end
        default: if (cmd_ack) begin
          m_cnt = (m_cnt + 1) % 256; m_fsk = 1'b1; m_mode = 0; m_bit = 0; pkts_done++;
        end
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    check(fsk_out === m_fsk, fsk_tag(), fsk_out, m_fsk);
    check(busy === (m_mode != 0), "R9 R10 busy", busy, m_mode != 0);
    check(cmd_valid === (m_mode == 1 || m_mode == 3), "R6 cmd_valid", cmd_valid, m_mode == 1 || m_mode == 3);
    if (m_mode == 1 || m_mode == 3)
      check(cmd_word === (m_mode == 3 ? OFW : ONW), "R6 cmd_word", cmd_word, m_mode == 3 ? OFW : ONW);
  end

  always @(negedge clk) cmd_ack <= cmd_valid && ($urandom_range(0, 2) != 0);

  initial begin
    bit_req_n = 1'b1;
    forever begin
      int hold;
      hold = fast ? 1 : $urandom_range(1, 3);
      repeat (hold) @(negedge clk);
      bit_req_n = ~bit_req_n;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_pkts(input int n);
    while (pkts_done < n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    pkts_done = 0;
    rst_n = 1'b0; start = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check(fsk_out === 1'b1, "R7 reset fsk_out", fsk_out, 1);
    check(busy === 1'b0, "R7 reset busy", busy, 0);
    check(cmd_valid === 1'b0, "R7 reset cmd_valid", cmd_valid, 0);
    for (int a = 0; a < 13; a++) wr(a, a * 17 + 3);
    wr(13, 8'hFF); wr(15, 8'h00);
    while (!busy) @(negedge clk);
    repeat (60) @(negedge clk);
    wr(2, 8'h00);
    pulse_start();
    wait_pkts(1);
    for (int a = 0; a < 13; a++) wr(a, 8'hFF - a);
    pulse_start();
    check(busy === 1'b1, "R10 start launches from idle", busy, 1);
    wait_pkts(2);
    begin
      int idle = 0;
      while (!busy) begin idle++; @(negedge clk); end
      check(idle == GAP, "R9 idle gap length", idle, GAP);
    end
    wait_pkts(3);
    fast = 1;
    while (pkts_done < 258) begin
      @(negedge clk);
      if (!busy && m_mode == 0) pulse_start();
    end
    check(pkts_done >= 257, "R8 counter wrapped", pkts_done, 257);
    repeat (20) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=%0d expected=%0d packets", pkts_done, 258);
    summary();
    $finish;
  end
endmodule